// File: doc/BRIEF.md
# Drive-side serial identification register

This block sits inside an external floppy-style drive and answers the host's identification protocol. It keeps a motor-on flip-flop that loads the inverted motor-data line whenever the drive-select strobe becomes active. It also keeps a 32-bit identification shift register whose bits are sent back on the active-low ready line, one bit for each select pulse.

The host turns the motor on and then off. The on-to-off change re-arms the register at its most significant bit. The host then pulses select 32 times and reads ready while each pulse is active. While the motor is on, ready means "disk present and spinning at speed", and the register does not move. All three strobe inputs are brought into the local clock domain through two-flop synchronisers, and edges are taken from the synchronised signals. The identification value is a build-time parameter.

Top module: `drive_id_unit`

## Requirements
- R1: The motor flip-flop is written only when select falls (sel_ni goes 1 to 0). It then takes the value of !mtr_ni, so mtr_ni low turns the motor on. A change of mtr_ni while select is held steady has no effect on ready.
- R2: While rst_ni is low, the motor is off and rdy_no is high. After reset the register holds the full ID with its most significant bit first, so the first select pulse with the motor off presents ID[31].
- R3: A select-fall edge that turns the motor off after it was on reloads the full ID and returns the bit pointer to the first bit. The pulse that re-arms does not use up a bit, so the next select pulse presents ID[31] again.
- R4: With the motor off, each select-active window presents one ID bit, starting with the most significant. The register advances when select is released, so 32 pulses read ID[31] down to ID[0].
- R5: The ID bit is presented inverted. A 1 bit drives rdy_no low and a 0 bit leaves it high.
- R6: Once all 32 bits have been read, further pulses with the motor off present rdy_no high until the next re-arm.
- R7: With the motor on and select active, rdy_no is low exactly when spin_ok_i is high.
- R8: When select is inactive, rdy_no is high.
- R9: ID_VALUE encodes the unit type: 32'h0000_0000 means no drive, 32'hFFFF_FFFF is the standard 3.5-inch unit (the default), and 32'h5555_5555 is a 48 TPI double-density double-sided unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local drive clock |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| sel_ni | input | 1 | Drive-select strobe, active low |
| mtr_ni | input | 1 | Motor data, active low, sampled when select becomes active |
| spin_ok_i | input | 1 | Disk present and up to speed |
| rdy_no | output | 1 | Ready / serial ID bit, active low |

## Verification
Every input passes through two synchroniser flops. A select edge is therefore seen during the third clock, and the motor and register state take it at the third rising edge. rdy_no follows combinationally from these flops, so it is settled no more than three edges after an input changes. The bench holds each select level for four clocks and samples 2 ns after a rising edge, which puts every sample after the result has settled and well before the next change of input.

// File: rtl/drive_id_pkg.sv
package drive_id_pkg;
  typedef enum logic [1:0] {
    RDY_RELEASE = 2'd0,
    RDY_SPIN    = 2'd1,
    RDY_IDBIT   = 2'd2
  } rdy_src_e;

  function automatic rdy_src_e pick_src(input logic sel_n, input logic motor_on);
    if (sel_n)         return RDY_RELEASE;
    else if (motor_on) return RDY_SPIN;
    else               return RDY_IDBIT;
  endfunction
endpackage

// File: rtl/drive_id_sync.sv
module drive_id_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/drive_id_edge.sv
module drive_id_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_n_i,
  output logic fall_o,
  output logic rise_o
);
  logic sel_n_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_n_d <= 1'b1;
    else         sel_n_d <= sel_n_i;
  end

  assign fall_o = sel_n_d & ~sel_n_i;
  assign rise_o = ~sel_n_d & sel_n_i;
endmodule

// File: rtl/drive_id_motor.sv
module drive_id_motor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic mtr_n_i,
  output logic motor_o,
  output logic off_edge_o
);
  logic motor_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       motor_q <= 1'b0;
    else if (strobe_i) motor_q <= ~mtr_n_i;
  end

  assign motor_o    = motor_q;
  assign off_edge_o = strobe_i & motor_q & mtr_n_i;
endmodule

// File: rtl/drive_id_shreg.sv
module drive_id_shreg #(
  parameter int unsigned ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = '1,
  localparam int unsigned CNT_W   = $clog2(ID_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  output logic             bit_o,
  output logic [ID_W-1:0]  data_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [ID_W-1:0]  data_q;
  logic [CNT_W-1:0] cnt_q;
  logic             skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= ID_VALUE;
      cnt_q  <= '0;
      skip_q <= 1'b0;
    end else if (load_i) begin
      data_q <= ID_VALUE;
      cnt_q  <= '0;
      skip_q <= 1'b1;
    end else if (adv_i) begin
      if (skip_q) begin
        skip_q <= 1'b0;
      end else begin
        data_q <= {data_q[ID_W-2:0], 1'b0};
        if (cnt_q != CNT_W'(ID_W)) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign bit_o  = data_q[ID_W-1];
  assign data_o = data_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/drive_id_unit.sv
module drive_id_unit #(
  parameter int unsigned ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'hFFFF_FFFF,
  localparam int unsigned CNT_W   = $clog2(ID_W + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic mtr_ni,
  input  logic spin_ok_i,
  output logic rdy_no
);
  import drive_id_pkg::*;

  logic [2:0]       sync_q;
  logic             sel_n_s, mtr_n_s, spin_s;
  logic             sel_fall, sel_rise;
  logic             motor_q, motor_off;
  logic             id_bit;
  logic [ID_W-1:0]  shreg;
  logic [CNT_W-1:0] cnt;
  rdy_src_e         src;

  drive_id_sync #(.W(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({spin_ok_i, mtr_ni, sel_ni}), .q_o(sync_q)
  );
  assign sel_n_s = sync_q[0];
  assign mtr_n_s = sync_q[1];
  assign spin_s  = sync_q[2];

  drive_id_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_n_i(sel_n_s),
    .fall_o(sel_fall), .rise_o(sel_rise)
  );

  drive_id_motor u_motor (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(sel_fall), .mtr_n_i(mtr_n_s),
    .motor_o(motor_q), .off_edge_o(motor_off)
  );

  drive_id_shreg #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_shreg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(motor_off), .adv_i(sel_rise & ~motor_q),
    .bit_o(id_bit), .data_o(shreg), .cnt_o(cnt)
  );

  always_comb begin
    src = pick_src(sel_n_s, motor_q);
    unique case (src)
      RDY_SPIN:  rdy_no = ~spin_s;
      RDY_IDBIT: rdy_no = ~id_bit;
      default:   rdy_no = 1'b1;
    endcase
  end
endmodule

// File: rtl/drive_id_unit_chk.sv
module drive_id_unit_chk #(
  parameter int unsigned ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'hFFFF_FFFF,
  localparam int unsigned CNT_W   = $clog2(ID_W + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_n_s,
  input logic             mtr_n_s,
  input logic             sel_fall,
  input logic             motor_q,
  input logic [ID_W-1:0]  shreg,
  input logic [CNT_W-1:0] cnt,
  input logic             rdy_no
);
  AST_MOTOR_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (motor_q != $past(motor_q)) |-> $past(sel_fall)); // R1

  AST_REARM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_fall && motor_q && mtr_n_s) |=> (shreg == ID_VALUE && cnt == '0)); // R3

  AST_RELEASED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_n_s |-> rdy_no); // R8

  AST_EXHAUSTED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(ID_W)) |-> (shreg == '0)); // R6

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != $past(cnt) && cnt != '0) |-> (cnt == $past(cnt) + CNT_W'(1))); // R4

  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(ID_W)); // R4
endmodule

bind drive_id_unit drive_id_unit_chk #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_n_s(sel_n_s), .mtr_n_s(mtr_n_s),
  .sel_fall(sel_fall), .motor_q(motor_q), .shreg(shreg), .cnt(cnt), .rdy_no(rdy_no)
);

// File: tb/drive_id_unit_tb.sv
module drive_id_unit_tb;
  localparam logic [31:0] ID_A = 32'hC5A3_96E1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic mtr_n = 1'b1;
  logic spin = 1'b0;
  logic rdy_a, rdy_std, rdy_none;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  drive_id_unit #(.ID_VALUE(ID_A)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .mtr_ni(mtr_n),
    .spin_ok_i(spin), .rdy_no(rdy_a));
  drive_id_unit u_std (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .mtr_ni(mtr_n),
    .spin_ok_i(spin), .rdy_no(rdy_std));
  drive_id_unit #(.ID_VALUE(32'h0000_0000)) u_none (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .mtr_ni(mtr_n),
    .spin_ok_i(spin), .rdy_no(rdy_none));

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rdy_no=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_settle();
    repeat (4) @(posedge clk);
    #2;
  endtask

  // one select pulse; samples all three outputs while select is active
  task automatic pulse(input logic mtr, output logic [2:0] rd);
    mtr_n = mtr;
    sel_n = 1'b0;
    wait_settle();
    rd = {rdy_none, rdy_std, rdy_a};
    sel_n = 1'b1;
    wait_settle();
  endtask

  task automatic rearm();
    logic [2:0] rd;
    pulse(1'b0, rd);
    pulse(1'b1, rd);
  endtask

  task automatic t_reset();
    logic [2:0] rd;
    #2;
    check("R2 reset rdy high", rdy_a, 1'b1);
    check("R8 idle after reset", rdy_std, 1'b1);
    @(posedge clk); #2 rst_n = 1'b1;
    wait_settle();
    check("R8 released", rdy_a, 1'b1);
    pulse(1'b1, rd);
    check("R2 first bit after reset", rd[0], ~ID_A[31]);
    pulse(1'b1, rd);
    check("R2 second bit after reset", rd[0], ~ID_A[30]);
  endtask

  task automatic t_motor_ready();
    logic [2:0] rd;
    spin = 1'b1;
    pulse(1'b0, rd);
    check("R7 motor on spinning", rd[0], 1'b0);
    spin = 1'b0;
    pulse(1'b0, rd);
    check("R7 motor on not spinning", rd[0], 1'b1);
    // hold select, flip motor data: motor must stay on (R1)
    mtr_n = 1'b0;
    sel_n = 1'b0;
    wait_settle();
    check("R7 held select motor on", rdy_a, 1'b1);
    mtr_n = 1'b1;
    wait_settle();
    check("R1 mtr change ignored while selected", rdy_a, 1'b1);
    spin = 1'b1;
    wait_settle();
    check("R7 spin follows", rdy_a, 1'b0);
    sel_n = 1'b1;
    wait_settle();
    check("R8 released while motor on", rdy_a, 1'b1);
    spin = 1'b0;
  endtask

  task automatic t_read_all();
    logic [2:0] rd;
    rearm();
    for (int i = 31; i >= 0; i--) begin
      pulse(1'b1, rd);
      check($sformatf("R4 R5 bit %0d", i), rd[0], ~ID_A[i]);
    end
    for (int k = 0; k < 3; k++) begin
      pulse(1'b1, rd);
      check("R6 exhausted", rd[0], 1'b1);
    end
  endtask

  task automatic t_rearm_mid();
    logic [2:0] rd;
    rearm();
    for (int i = 31; i >= 27; i--) pulse(1'b1, rd);
    rearm();
    for (int i = 31; i >= 29; i--) begin
      pulse(1'b1, rd);
      check($sformatf("R3 rearm bit %0d", i), rd[0], ~ID_A[i]);
    end
  endtask

  task automatic t_encodings();
    logic [2:0] rd;
    rearm();
    for (int i = 31; i >= 0; i--) begin
      pulse(1'b1, rd);
      check($sformatf("R9 standard bit %0d", i), rd[1], 1'b0);
      check($sformatf("R9 no-drive bit %0d", i), rd[2], 1'b1);
    end
    pulse(1'b1, rd);
    check("R6 standard exhausted", rd[1], 1'b1);
  endtask

  initial begin
    t_reset();
    t_motor_ready();
    t_read_all();
    t_rearm_mid();
    t_encodings();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule